// File: doc/BRIEF.md
# DAC Command Decoder and Configuration Registers

This block sits behind the serial frame receiver of a four-channel DAC. Each committed 32-bit frame is split into a read flag, a 4-bit opcode, a 4-bit channel address, a 16-bit left-justified data field and 4 low select bits. From these it raises single-cycle strobes for the update controller: buffer writes, channel updates, software clear and software reset. It also holds the configuration state that the rest of the device reads: per-channel power-down modes, the clear-mode code, the per-channel synchronous-update bypass mask, the serial-output enable and the per-channel reduced current-limit flags.

A read frame writes nothing. Instead it prepares a 32-bit readback word that the frame receiver shifts out during the next frame. A ready flag rises a fixed number of clocks after reset and is visible through the status readback.

Frames arrive on a valid/ready stream. `frame_ready` is high in every cycle that reset is not asserted, so the block never applies back-pressure. A frame is consumed on each rising clock edge where both `frame_valid` and `frame_ready` are high. The sender may hold `frame_valid` high across consecutive cycles, and each such cycle delivers a new frame.

Top module: `dac_cmd_decoder`

## Requirements
- R1: `frame_ready` is 0 while `rst_n` is low and 1 otherwise. A frame is taken on a rising edge with `frame_valid` and `frame_ready` both high, and all results appear right after that edge. With no frame taken, every strobe is 0 and `rd_word` holds its value.
- R2: The frame fields are: bit 28 read flag, bits 27:24 opcode, bits 23:20 address, bits 19:4 data, bits 3:0 select. Bits 31:29 are ignored. Address 0..3 selects channel 0..3 and address 4'hF selects all channels; any other address selects none. `buf_wr_data` carries bits 19:4 of the last frame taken.
- R3: For write frames, opcode 0000 pulses `buf_wr_en` for the addressed channels. Opcode 0001 pulses `upd_en` for the addressed channels. Opcode 0010 pulses `buf_wr_en` for the addressed channels and `upd_en` for all four. Opcode 0011 pulses both for the addressed channels. Each pulse lasts one cycle.
- R4: A write with opcode 0100 sets the 2-bit mode from frame bits 9:8 for each channel whose select bit (3:0) is 1, and leaves the other channels unchanged. Channel k's mode sits at `pd_mode[2k+1:2k]`. The modes are 00 normal, 01 strong pull-down, 10 weak pull-down and 11 high-impedance.
- R5: A write with opcode 0101 loads `clr_mode` from bits 1:0. Opcode 0110 loads `sync_bypass` from bits 3:0. Opcode 1000 loads `sdo_en` from bit 1. Opcode 1010 loads `ilim_low` from bits 3:0.
- R6: A write with opcode 0111 returns every configuration register to zero and pulses `sw_reset` for one cycle.
- R7: A write with opcode 1011 pulses `sw_clear` for one cycle and changes no configuration.
- R8: Write frames with opcode 1001, 1100, 1101, 1110 or 1111 change no register and raise no strobe.
- R9: A read frame (bit 28 = 1) changes no register and raises no strobe. It loads `rd_word` with the opcode in bits 27:24 and the selected content in write-format positions; every other bit is 0. The content is: opcode 0100 gives channel k's mode at bits 9+2k:8+2k; 0101 gives clear mode at 1:0; 0110 gives the bypass mask at 3:0; 1000 gives SDO enable at bit 1; 1010 gives the current-limit flags at 3:0; 1101 gives the ready flag at bit 4. Any write frame loads `rd_word` with 0.
- R10: `dev_ready` becomes 1 exactly READY_DELAY rising edges after `rst_n` rises, then stays 1. Software reset does not affect it.
- R11: While `rst_n` is low, all configuration outputs, strobes, `buf_wr_data` and `rd_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | Committed frame present |
| frame_ready | output | 1 | Block accepts frames (high out of reset) |
| frame_data | input | 32 | Committed frame |
| buf_wr_en | output | 4 | Per-channel buffer write strobe |
| buf_wr_data | output | 16 | Data field of the last accepted frame |
| upd_en | output | 4 | Per-channel update strobe |
| sw_clear | output | 1 | Software clear strobe |
| sw_reset | output | 1 | Software reset strobe |
| pd_mode | output | 8 | Power-down mode, 2 bits per channel |
| clr_mode | output | 2 | Clear-mode code |
| sync_bypass | output | 4 | Per-channel synchronous-update bypass |
| sdo_en | output | 1 | Serial output enable |
| ilim_low | output | 4 | Per-channel reduced current limit |
| dev_ready | output | 1 | Ready status flag |
| rd_word | output | 32 | Readback word for the next frame |

## Verification
Every result of an accepted frame appears right after the edge that takes it: strobes, register changes and `rd_word`. The bench therefore drives each frame at a falling edge and samples all outputs 1 ns after the next rising edge. It checks strobe fall-back and readback hold one cycle later with no frame offered. The ready flag is probed 1 ns after the 15th and 16th edges following reset release, so an off-by-one delay is caught on either side.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam int FW  = 32;
  localparam int PDW = 2;
  localparam int AW  = 4;

  typedef enum logic [3:0] {
    OP_WRBUF   = 4'h0,
    OP_UPD     = 4'h1,
    OP_WRB_UPA = 4'h2,
    OP_WRUPD   = 4'h3,
    OP_PWR     = 4'h4,
    OP_CLRMODE = 4'h5,
    OP_BYPASS  = 4'h6,
    OP_SWRST   = 4'h7,
    OP_SDOEN   = 4'h8,
    OP_RSV9    = 4'h9,
    OP_ILIM    = 4'hA,
    OP_SWCLR   = 4'hB,
    OP_RSVC    = 4'hC,
    OP_STATUS  = 4'hD,
    OP_NOP     = 4'hE,
    OP_RSVF    = 4'hF
  } op_e;

  typedef struct packed {
    logic            rd;
    op_e             op;
    logic [AW-1:0]   addr;
    logic [DW-1:0]   data;
    logic [NCH-1:0]  sel;
  } fields_t;

  typedef struct packed {
    logic [NCH*PDW-1:0] pd;
    logic [1:0]         clr;
    logic [NCH-1:0]     bypass;
    logic               sdo;
    logic [NCH-1:0]     ilim;
  } cfg_t;
endpackage

// File: rtl/dac_cmd_field_dec.sv
module dac_cmd_field_dec
  import dac_cmd_pkg::*;
(
  input  logic [FW-1:0] frame,
  output fields_t       fld,
  output logic [NCH-1:0] chan_hit
);
  localparam logic [AW-1:0] ADDR_ALL = '1;

  always_comb begin
    fld.rd   = frame[28];
    fld.op   = op_e'(frame[27:24]);
    fld.addr = frame[23:20];
    fld.data = frame[19:4];
    fld.sel  = frame[NCH-1:0];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_hit
    assign chan_hit[g] = (frame[23:20] == ADDR_ALL) || (frame[23:20] == AW'(g));
  end
endmodule

// File: rtl/dac_cmd_cfg_regs.sv
module dac_cmd_cfg_regs
  import dac_cmd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  fields_t        fld,
  input  logic [NCH-1:0] chan_hit,
  output cfg_t           cfg,
  output logic [NCH-1:0] buf_wr_en,
  output logic [DW-1:0]  buf_wr_data,
  output logic [NCH-1:0] upd_en,
  output logic           sw_clear,
  output logic           sw_reset
);
  logic wr;
  assign wr = accept && !fld.rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg         <= '0;
      buf_wr_en   <= '0;
      buf_wr_data <= '0;
      upd_en      <= '0;
      sw_clear    <= 1'b0;
      sw_reset    <= 1'b0;
    end else begin
      buf_wr_en <= '0;
      upd_en    <= '0;
      sw_clear  <= 1'b0;
      sw_reset  <= 1'b0;
      if (accept) buf_wr_data <= fld.data;
      if (wr) begin
        case (fld.op)
          OP_WRBUF:   buf_wr_en <= chan_hit;
          OP_UPD:     upd_en <= chan_hit;
          OP_WRB_UPA: begin
            buf_wr_en <= chan_hit;
            upd_en    <= '1;
          end
          OP_WRUPD: begin
            buf_wr_en <= chan_hit;
            upd_en    <= chan_hit;
          end
          OP_PWR: begin
            for (int i = 0; i < NCH; i++)
              if (fld.sel[i]) cfg.pd[i*PDW +: PDW] <= fld.data[5:4];
          end
          OP_CLRMODE: cfg.clr <= fld.sel[1:0];
          OP_BYPASS:  cfg.bypass <= fld.sel;
          OP_SWRST: begin
            cfg      <= '0;
            sw_reset <= 1'b1;
          end
          OP_SDOEN:   cfg.sdo <= fld.sel[1];
          OP_ILIM:    cfg.ilim <= fld.sel;
          OP_SWCLR:   sw_clear <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assert_addr_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(buf_wr_en) <= 1) || (buf_wr_en == '1));

  assert_read_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fld.rd) |=> ($stable(cfg) && buf_wr_en == '0 && upd_en == '0
                            && !sw_clear && !sw_reset));

  assert_reserved_noeffect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (fld.op == OP_RSV9 || fld.op == OP_RSVC || fld.op == OP_STATUS ||
            fld.op == OP_NOP || fld.op == OP_RSVF))
    |=> ($stable(cfg) && buf_wr_en == '0 && upd_en == '0 && !sw_clear && !sw_reset));

  assert_swrst_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && fld.op == OP_SWRST) |=> (cfg == '0 && sw_reset));

  assert_clr_keeps_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |-> $stable(cfg));
endmodule

// File: rtl/dac_cmd_readback.sv
module dac_cmd_readback
  import dac_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  fields_t       fld,
  input  cfg_t          cfg,
  input  logic          ready,
  output logic [FW-1:0] rd_word
);
  logic [FW-1:0] next_word;

  always_comb begin
    next_word = '0;
    if (fld.rd) begin
      next_word[27:24] = fld.op;
      case (fld.op)
        OP_PWR:     next_word[8 +: NCH*PDW] = cfg.pd;
        OP_CLRMODE: next_word[1:0] = cfg.clr;
        OP_BYPASS:  next_word[NCH-1:0] = cfg.bypass;
        OP_SDOEN:   next_word[1] = cfg.sdo;
        OP_ILIM:    next_word[NCH-1:0] = cfg.ilim;
        OP_STATUS:  next_word[4] = ready;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_word <= '0;
    else if (accept) rd_word <= next_word;
  end

  assert_status_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fld.rd && fld.op == OP_STATUS) |=> (rd_word[4] == $past(ready)));

  assert_write_zero_rb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !fld.rd) |=> (rd_word == '0));

  assert_rb_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(rd_word));
endmodule

// File: rtl/dac_cmd_ready_timer.sv
module dac_cmd_ready_timer #(
  parameter int DELAY = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int CW = $clog2(DELAY + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt   <= cnt + 1'b1;
      ready <= (cnt == CW'(DELAY - 1));
    end
  end

  assert_ready_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
  import dac_cmd_pkg::*;
#(
  parameter int READY_DELAY = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_valid,
  output logic                frame_ready,
  input  logic [FW-1:0]       frame_data,
  output logic [NCH-1:0]      buf_wr_en,
  output logic [DW-1:0]       buf_wr_data,
  output logic [NCH-1:0]      upd_en,
  output logic                sw_clear,
  output logic                sw_reset,
  output logic [NCH*PDW-1:0]  pd_mode,
  output logic [1:0]          clr_mode,
  output logic [NCH-1:0]      sync_bypass,
  output logic                sdo_en,
  output logic [NCH-1:0]      ilim_low,
  output logic                dev_ready,
  output logic [FW-1:0]       rd_word
);
  fields_t        fld;
  logic [NCH-1:0] chan_hit;
  cfg_t           cfg;
  logic           accept;

  assign frame_ready = rst_n;
  assign accept      = frame_valid && frame_ready;

  dac_cmd_field_dec u_dec (
    .frame    (frame_data),
    .fld      (fld),
    .chan_hit (chan_hit)
  );

  dac_cmd_cfg_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .fld         (fld),
    .chan_hit    (chan_hit),
    .cfg         (cfg),
    .buf_wr_en   (buf_wr_en),
    .buf_wr_data (buf_wr_data),
    .upd_en      (upd_en),
    .sw_clear    (sw_clear),
    .sw_reset    (sw_reset)
  );

  dac_cmd_ready_timer #(.DELAY(READY_DELAY)) u_rdy (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (dev_ready)
  );

  dac_cmd_readback u_rb (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .fld     (fld),
    .cfg     (cfg),
    .ready   (dev_ready),
    .rd_word (rd_word)
  );

  assign pd_mode     = cfg.pd;
  assign clr_mode    = cfg.clr;
  assign sync_bypass = cfg.bypass;
  assign sdo_en      = cfg.sdo;
  assign ilim_low    = cfg.ilim;
endmodule

// File: tb/dac_cmd_decoder_bench.sv
module dac_cmd_decoder_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        frame_valid = 1'b0;
  logic        frame_ready;
  logic [31:0] frame_data = '0;
  logic [3:0]  buf_wr_en, upd_en, sync_bypass, ilim_low;
  logic [15:0] buf_wr_data;
  logic        sw_clear, sw_reset, sdo_en, dev_ready;
  logic [7:0]  pd_mode;
  logic [1:0]  clr_mode;
  logic [31:0] rd_word;

  dac_cmd_decoder u_dac_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_ready(frame_ready),
    .frame_data(frame_data), .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data),
    .upd_en(upd_en), .sw_clear(sw_clear), .sw_reset(sw_reset), .pd_mode(pd_mode),
    .clr_mode(clr_mode), .sync_bypass(sync_bypass), .sdo_en(sdo_en),
    .ilim_low(ilim_low), .dev_ready(dev_ready), .rd_word(rd_word)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0]  m_pd = '0;
  logic [1:0]  m_clr = '0;
  logic [3:0]  m_byp = '0, m_ilim = '0;
  logic        m_sdo = 1'b0;
  logic [31:0] m_rd = '0;
  logic [3:0]  e_bwr, e_upd;
  logic        e_swc, e_swr;
  logic [15:0] e_data;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] hit(input logic [3:0] a);
    if (a == 4'hF) return 4'hF;
    if (a < 4'd4) return 4'b0001 << a;
    return 4'h0;
  endfunction

  function automatic logic [31:0] mk(input logic rd, input logic [3:0] op,
      input logic [3:0] addr, input logic [15:0] data, input logic [3:0] sel);
    return {3'b000, rd, op, addr, data, sel};
  endfunction

  task automatic model(input logic [31:0] f);
    logic [3:0] op = f[27:24];
    logic [3:0] h  = hit(f[23:20]);
    logic [3:0] s  = f[3:0];
    e_bwr = '0; e_upd = '0; e_swc = 1'b0; e_swr = 1'b0; e_data = f[19:4];
    if (f[28]) begin
      m_rd = {4'h0, op, 24'h0};
      case (op)
        4'h4: m_rd[15:8] = m_pd;
        4'h5: m_rd[1:0]  = m_clr;
        4'h6: m_rd[3:0]  = m_byp;
        4'h8: m_rd[1]    = m_sdo;
        4'hA: m_rd[3:0]  = m_ilim;
        4'hD: m_rd[4]    = 1'b1;
        default: ;
      endcase
    end else begin
      m_rd = '0;
      case (op)
        4'h0: e_bwr = h;
        4'h1: e_upd = h;
        4'h2: begin e_bwr = h; e_upd = 4'hF; end
        4'h3: begin e_bwr = h; e_upd = h; end
        4'h4: for (int i = 0; i < 4; i++) if (s[i]) m_pd[2*i +: 2] = f[9:8];
        4'h5: m_clr = s[1:0];
        4'h6: m_byp = s;
        4'h7: begin m_pd = '0; m_clr = '0; m_byp = '0; m_sdo = 1'b0; m_ilim = '0; e_swr = 1'b1; end
        4'h8: m_sdo = s[1];
        4'hA: m_ilim = s;
        4'hB: e_swc = 1'b1;
        default: ;
      endcase
    end
  endtask

  task automatic compare_all(input string tag);
    check({"R3 ", tag}, "buf_wr_en", 32'(buf_wr_en), 32'(e_bwr));
    check({"R3 ", tag}, "upd_en", 32'(upd_en), 32'(e_upd));
    check({"R2 ", tag}, "buf_wr_data", 32'(buf_wr_data), 32'(e_data));
    check({"R7 ", tag}, "sw_clear", 32'(sw_clear), 32'(e_swc));
    check({"R6 ", tag}, "sw_reset", 32'(sw_reset), 32'(e_swr));
    check({"R4 ", tag}, "pd_mode", 32'(pd_mode), 32'(m_pd));
    check({"R5 ", tag}, "cfg", {21'h0, clr_mode, sync_bypass, sdo_en, ilim_low},
          {21'h0, m_clr, m_byp, m_sdo, m_ilim});
    check({"R9 ", tag}, "rd_word", rd_word, m_rd);
  endtask

  task automatic send(input logic [31:0] f, input string tag);
    @(negedge clk);
    frame_valid = 1'b1;
    frame_data  = f;
    model(f);
    @(posedge clk);
    #1;
    frame_valid = 1'b0;
    compare_all(tag);
  endtask

  task automatic idle_check();
    logic [31:0] rd_before = rd_word;
    @(posedge clk);
    #1;
    check("R1 idle", "strobes", {buf_wr_en, upd_en, sw_clear, sw_reset}, '0);
    check("R1 idle", "rd_word hold", rd_word, rd_before);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL R1 watchdog actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(posedge clk);
    #1;
    check("R11", "reset outputs",
          {rd_word[15:0] | rd_word[31:16], buf_wr_data},
          32'h0);
    check("R11", "reset cfg/strobes",
          {8'h0, pd_mode, clr_mode, sync_bypass, sdo_en, ilim_low, buf_wr_en, sw_clear, sw_reset}, 32'h0);
    check("R1", "frame_ready in reset", 32'(frame_ready), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1", "frame_ready out of reset", 32'(frame_ready), 32'h1);
    repeat (15) @(posedge clk);
    #1 check("R10", "ready after 15 edges", 32'(dev_ready), 32'h0);
    @(posedge clk);
    #1 check("R10", "ready after 16 edges", 32'(dev_ready), 32'h1);

    send(mk(0, 4'h0, 4'h2, 16'hBEEF, 4'h0), "write ch2");
    idle_check();
    send(mk(0, 4'h0, 4'hF, 16'h1234, 4'h0), "write all");
    send(mk(0, 4'h0, 4'h7, 16'h5555, 4'h0), "addr none");
    send({3'b111, mk(0, 4'h3, 4'h1, 16'hA5A5, 4'h0)} | 32'hE000_0000, "top bits ignored");
    send(mk(0, 4'h2, 4'h3, 16'h0F0F, 4'h0), "write upd all");
    send(mk(0, 4'h1, 4'h0, 16'h0, 4'h0), "update ch0");
    send(mk(0, 4'h4, 4'h0, 16'h0030, 4'b0101), "pd mode 11 ch0 ch2");
    send(mk(0, 4'h4, 4'h0, 16'h0010, 4'b0010), "pd mode 01 ch1");
    send(mk(0, 4'h5, 4'h0, 16'h0, 4'b0010), "clear mode");
    send(mk(0, 4'h6, 4'h0, 16'h0, 4'b1001), "bypass");
    send(mk(0, 4'h8, 4'h0, 16'h0, 4'b0010), "sdo en");
    send(mk(0, 4'hA, 4'h0, 16'h0, 4'b0110), "ilim");
    send(mk(1, 4'h4, 4'h0, 16'h0, 4'h0), "read pd");
    idle_check();
    send(mk(1, 4'hD, 4'h0, 16'h0, 4'h0), "read status");
    check("R10", "status ready bit", 32'(rd_word[4]), 32'h1);
    send(mk(1, 4'h7, 4'h0, 16'h0, 4'h0), "read of swrst does nothing");
    send(mk(1, 4'h0, 4'h1, 16'hFFFF, 4'h0), "read buf echo");
    send(mk(0, 4'hE, 4'h0, 16'h0, 4'h0), "nop clears rb");
    for (int op = 9; op <= 15; op++)
      if (op == 9 || op >= 12)
        send(mk(0, 4'(op), 4'hF, 16'hFFFF, 4'hF), "R8 no effect");
    send(mk(0, 4'hB, 4'h0, 16'h0, 4'hF), "sw clear");
    send(mk(0, 4'h7, 4'h0, 16'h0, 4'h0), "sw reset");
    check("R10", "ready after sw reset", 32'(dev_ready), 32'h1);

    for (int n = 0; n < 400; n++) begin
      logic [3:0] op = 4'($urandom_range(0, 15));
      logic [3:0] ad;
      case ($urandom_range(0, 3))
        0: ad = 4'hF;
        1: ad = 4'($urandom_range(4, 14));
        default: ad = 4'($urandom_range(0, 3));
      endcase
      if (op == 4'h7 && $urandom_range(0, 3) != 0) op = 4'h4;
      send(mk(1'($urandom_range(0, 4) == 0), op, ad, 16'($urandom), 4'($urandom)), "random");
      if ($urandom_range(0, 7) == 0) idle_check();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule